// File: doc/BRIEF.md
# Program-Memory Table Read Unit

This block lets a small microcontroller core fetch constant data held in program memory. Software first loads an 8-bit index register over the special-register bus. It then issues a table-read operation. The operation forms a full program-memory address from that index and a page number. In current-page mode the page comes from the upper bits of the program counter. In last-page mode the page bits are all ones. The block reads the word through a synchronous ROM port. It writes the word's low byte to a data-memory address supplied by the core. It keeps the bits above bit 7 in a read-only high-byte register.

Every operation takes two cycles. The sequencer has two named states. ST_IDLE is the resting state. In it, a start pulse drives the ROM enable and the address, captures the destination, and moves the sequencer to ST_FETCH (transition IDLE->FETCH). In ST_FETCH the busy output stalls the core and the low-byte write strobe is asserted. The high-byte register loads at the clock edge that ends ST_FETCH. The sequencer then always returns to ST_IDLE (transition FETCH->IDLE). Each new read replaces the high byte. The block makes no copy of the old value, so a read made at interrupt level destroys a value the main code has not yet saved.

Top module: `tblrd_unit`

## Requirements
- R1: When start is high in ST_IDLE with start_last=0, rom_en is 1 in that same cycle and rom_addr equals {pc_page, index}, where index is the value the index register held before that cycle's edge.
- R2: When start is high in ST_IDLE with start_last=1, rom_addr equals {all ones, index}.
- R3: The index register is at special-register address 07h. A write with sfr_wr=1 stores sfr_wdata at the clock edge. Reading address 07h returns the stored value on sfr_rdata combinationally.
- R4: The high-byte register is at special-register address 08h. Its value can be read there, and writes to 08h leave it unchanged.
- R5: In the cycle after a start, dm_we is 1, dm_addr equals the dst_addr given with the start, and dm_wdata equals bits 7:0 of the fetched word.
- R6: From the edge that ends the second cycle, the high-byte register holds bits WORD_W-1:8 of the fetched word, zero-extended to 8 bits.
- R7: busy is 1 in exactly the one cycle after a start. While busy is 1, a start is ignored: rom_en stays 0, and the cycle after shows busy=0 and dm_we=0.
- R8: A later table read overwrites the high-byte register with its own word's upper bits.
- R9: After reset the index and high-byte registers read 00h, and busy, dm_we and rom_en are 0.
- R10: Special-register addresses other than 07h and 08h read as 00h.
- R11: If the index is written in the same cycle as a start, the address uses the old index, and the new value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Special-register bus address |
| sfr_wr | input | 1 | Special-register write strobe |
| sfr_wdata | input | 8 | Special-register write data |
| sfr_rdata | output | 8 | Special-register read data |
| start | input | 1 | Begin a table read |
| start_last | input | 1 | Page select: 0 current page, 1 last page |
| pc_page | input | PC_W-8 | Upper (page) bits of the program counter |
| dst_addr | input | DA_W | Destination data-memory address for the low byte |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | PC_W | ROM word address |
| rom_data | input | WORD_W | ROM word, valid the cycle after rom_en |
| busy | output | 1 | Stall request to the core |
| dm_we | output | 1 | Data-memory write strobe for the low byte |
| dm_addr | output | DA_W | Data-memory write address |
| dm_wdata | output | 8 | Data-memory write data (low byte) |

## Verification
A vector table runs reads in both page modes. Index values 00h, FFh and values in between show whether the index bits and the page bits are kept apart. Program-counter pages of all zeros, all ones and mixed values show whether last-page mode truly forces the upper bits. A page of all ones in current-page mode cannot be told apart from last-page mode by address alone, so the bench also uses mixed pages there. Directed tests cover writes to the read-only register, unmapped reads, a start raised while busy, back-to-back overwrites of the high byte, and an index write in the same cycle as a start.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } seq_state_t;

    typedef enum logic [0:0] {
        PG_CURRENT = 1'b0,
        PG_LAST    = 1'b1
    } page_mode_t;

    localparam logic [7:0] SFR_IDX_ADDR = 8'h07;
    localparam logic [7:0] SFR_HB_ADDR  = 8'h08;

endpackage

// File: rtl/tblrd_regs.sv
module tblrd_regs
    import tblrd_pkg::*;
#(
    parameter int WORD_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          sfr_addr,
    input  logic                sfr_wr,
    input  logic [7:0]          sfr_wdata,
    output logic [7:0]          sfr_rdata,
    input  logic                hb_load,
    input  logic [WORD_W-9:0]   hb_in,
    output logic [7:0]          idx_q
);
    localparam int HB_W = WORD_W - 8;

    logic [HB_W-1:0] hb_q;
    logic            idx_wr;

    assign idx_wr = sfr_wr && (sfr_addr == SFR_IDX_ADDR);

    // R3 / R11: index register, written only from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
        end else if (idx_wr) begin
            idx_q <= sfr_wdata;
        end
    end

    // R4 / R6 / R8: high byte loaded only by the sequencer, never from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hb_q <= '0;
        end else if (hb_load) begin
            hb_q <= hb_in;
        end
    end

    // R10: unmapped addresses return zero
    always_comb begin
        case (sfr_addr)
            SFR_IDX_ADDR: sfr_rdata = idx_q;
            SFR_HB_ADDR:  sfr_rdata = 8'(hb_q);
            default:      sfr_rdata = 8'h00;
        endcase
    end

    p_hb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hb_load |=> $stable(hb_q));

    p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_wr && sfr_addr == SFR_IDX_ADDR) |=> $stable(idx_q));

endmodule

// File: rtl/tblrd_addr_gen.sv
module tblrd_addr_gen
    import tblrd_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  page_mode_t          mode,
    input  logic [PC_W-9:0]     pc_page,
    input  logic [7:0]          idx,
    output logic [PC_W-1:0]     addr
);
    localparam int PAGE_W = PC_W - 8;

    logic [PAGE_W-1:0] page_sel;

    always_comb begin
        unique case (mode)
            PG_CURRENT: page_sel = pc_page;
            PG_LAST:    page_sel = '1;
        endcase
    end

    assign addr = {page_sel, idx};

endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq
    import tblrd_pkg::*;
#(
    parameter int DA_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [DA_W-1:0] dst_addr,
    output logic            rom_en,
    output logic            busy,
    output logic            hb_load,
    output logic [DA_W-1:0] dst_q
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q <= '0;
        end else if (rom_en) begin
            dst_q <= dst_addr;
        end
    end

    always_comb begin
        state_d = state_q;
        rom_en  = 1'b0;
        busy    = 1'b0;
        hb_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    rom_en  = 1'b1;
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                busy    = 1'b1;
                hb_load = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

    p_busy_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> busy);

    p_busy_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_no_fetch_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rom_en);

endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
    import tblrd_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int WORD_W = 14,
    parameter int DA_W   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          sfr_addr,
    input  logic                sfr_wr,
    input  logic [7:0]          sfr_wdata,
    output logic [7:0]          sfr_rdata,
    input  logic                start,
    input  logic                start_last,
    input  logic [PC_W-9:0]     pc_page,
    input  logic [DA_W-1:0]     dst_addr,
    output logic                rom_en,
    output logic [PC_W-1:0]     rom_addr,
    input  logic [WORD_W-1:0]   rom_data,
    output logic                busy,
    output logic                dm_we,
    output logic [DA_W-1:0]     dm_addr,
    output logic [7:0]          dm_wdata
);
    localparam int PAGE_W = PC_W - 8;

    logic       hb_load;
    logic [7:0] idx;
    page_mode_t mode;

    assign mode = start_last ? PG_LAST : PG_CURRENT;

    tblrd_seq #(.DA_W(DA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dst_addr (dst_addr),
        .rom_en   (rom_en),
        .busy     (busy),
        .hb_load  (hb_load),
        .dst_q    (dm_addr)
    );

    tblrd_addr_gen #(.PC_W(PC_W)) u_addr (
        .mode    (mode),
        .pc_page (pc_page),
        .idx     (idx),
        .addr    (rom_addr)
    );

    tblrd_regs #(.WORD_W(WORD_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .hb_load   (hb_load),
        .hb_in     (rom_data[WORD_W-1:8]),
        .idx_q     (idx)
    );

    // R5: low byte written in the second cycle
    assign dm_we    = busy;
    assign dm_wdata = rom_data[7:0];

    p_write_follows_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> $past(rom_en));

    p_last_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_en && start_last) |-> (rom_addr[PC_W-1:8] == {PAGE_W{1'b1}}));

    p_current_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_en && !start_last) |-> (rom_addr[PC_W-1:8] == pc_page));

endmodule

// File: tb/test_tblrd_unit.sv
module test_tblrd_unit;

    localparam int PC_W   = 12;
    localparam int WORD_W = 14;
    localparam int DA_W   = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        sfr_addr = 8'h00;
    logic              sfr_wr = 1'b0;
    logic [7:0]        sfr_wdata = 8'h00;
    logic [7:0]        sfr_rdata;
    logic              start = 1'b0;
    logic              start_last = 1'b0;
    logic [PC_W-9:0]   pc_page = '0;
    logic [DA_W-1:0]   dst_addr = '0;
    logic              rom_en;
    logic [PC_W-1:0]   rom_addr;
    logic [WORD_W-1:0] rom_data;
    logic              busy;
    logic              dm_we;
    logic [DA_W-1:0]   dm_addr;
    logic [7:0]        dm_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tblrd_unit #(.PC_W(PC_W), .WORD_W(WORD_W), .DA_W(DA_W)) i_tblrd_unit (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .start(start),
        .start_last(start_last), .pc_page(pc_page), .dst_addr(dst_addr),
        .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_data),
        .busy(busy), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
    );

    function automatic logic [WORD_W-1:0] rom_fn(input logic [PC_W-1:0] a);
        logic [31:0] v;
        v = (32'(a) * 32'd613) ^ 32'h2A5C;
        return v[WORD_W-1:0];
    endfunction

    // synchronous ROM model
    always @(posedge clk) begin
        if (rom_en) rom_data <= rom_fn(rom_addr);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] hb_of(input logic [WORD_W-1:0] w);
        return 8'(w >> 8);
    endfunction

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wr = 1'b1; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    // mode, pc_page, index, dst
    localparam logic [27:0] VEC [0:5] = '{
        {1'b0, 12'h3A7, 8'h00, 7'h28},
        {1'b0, 12'hF12, 8'hFF, 7'h7F},
        {1'b1, 12'h000, 8'h5C, 7'h40},
        {1'b1, 12'h8C3, 8'hFF, 7'h00},
        {1'b0, 12'h0FF, 8'h81, 7'h33},
        {1'b0, 12'hE00, 8'h01, 7'h55}
    };

    // one full read: start cycle then fetch cycle; checks address and low byte
    task automatic do_read(input logic m, input logic [PC_W-9:0] pg,
                           input logic [7:0] ix, input logic [DA_W-1:0] d,
                           output logic [WORD_W-1:0] w);
        logic [PC_W-1:0] ea;
        ea = {(m ? {(PC_W-8){1'b1}} : pg), ix};
        w  = rom_fn(ea);
        @(negedge clk);
        start = 1'b1; start_last = m; pc_page = pg; dst_addr = d;
        #1;
        chk("R1 rom_en in start cycle", 32'(rom_en), 1);
        if (m) chk("R2 last-page address", 32'(rom_addr), 32'(ea));
        else   chk("R1 current-page address", 32'(rom_addr), 32'(ea));
        @(negedge clk);
        start = 1'b0; dst_addr = '0;
        #1;
        chk("R7 busy in second cycle", 32'(busy), 1);
        chk("R5 dm_we", 32'(dm_we), 1);
        chk("R5 dm_addr", 32'(dm_addr), 32'(d));
        chk("R5 dm_wdata low byte", 32'(dm_wdata), 32'(w[7:0]));
    endtask

    logic [7:0] rd;
    logic [WORD_W-1:0] w1, w2;

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R9 busy at reset", 32'(busy), 0);
        chk("R9 dm_we at reset", 32'(dm_we), 0);
        chk("R9 rom_en at reset", 32'(rom_en), 0);
        @(negedge clk);
        rst_n = 1'b1;
        sfr_read(SFR_IDX(), rd);
        chk("R9 index after reset", 32'(rd), 0);
        sfr_read(8'h08, rd);
        chk("R9 high byte after reset", 32'(rd), 0);

        // vector table
        for (int i = 0; i < 6; i++) begin
            logic m;
            logic [11:0] pg;
            logic [7:0] ix;
            logic [6:0] d;
            {m, pg, ix, d} = VEC[i];
            sfr_write(8'h07, ix);
            sfr_read(8'h07, rd);
            chk("R3 index readback", 32'(rd), 32'(ix));
            do_read(m, pg[PC_W-9:0], ix, d, w1);
            @(negedge clk);
            #1;
            chk("R7 busy cleared", 32'(busy), 0);
            sfr_read(8'h08, rd);
            chk("R6 high byte", 32'(rd), 32'(hb_of(w1)));
        end

        // R4: write to high byte ignored
        sfr_read(8'h08, rd);
        w2 = WORD_W'(rd);
        sfr_write(8'h08, ~rd);
        sfr_read(8'h08, rd);
        chk("R4 high byte write ignored", 32'(rd), 32'(w2[7:0]));

        // R10: unmapped reads
        sfr_write(8'h05, 8'hA5);
        sfr_read(8'h05, rd);
        chk("R10 unmapped 05h reads 0", 32'(rd), 0);
        sfr_read(8'h09, rd);
        chk("R10 unmapped 09h reads 0", 32'(rd), 0);

        // R8: back-to-back reads, second overwrites high byte
        sfr_write(8'h07, 8'h10);
        do_read(1'b0, 4'h2, 8'h10, 7'h11, w1);
        do_read(1'b1, 4'h2, 8'h10, 7'h12, w2);
        @(negedge clk);
        sfr_read(8'h08, rd);
        chk("R8 overwrite by later read", 32'(rd), 32'(hb_of(w2)));

        // R7: start while busy is ignored
        sfr_write(8'h07, 8'h33);
        @(negedge clk);
        start = 1'b1; start_last = 1'b0; pc_page = 4'h5; dst_addr = 7'h21;
        @(negedge clk);
        start = 1'b1; start_last = 1'b1; dst_addr = 7'h22;
        #1;
        chk("R7 rom_en low while busy", 32'(rom_en), 0);
        chk("R7 dm_addr from first start", 32'(dm_addr), 32'h21);
        @(negedge clk);
        start = 1'b0;
        #1;
        chk("R7 no second busy", 32'(busy), 0);
        chk("R7 no second write", 32'(dm_we), 0);
        sfr_read(8'h08, rd);
        chk("R7 high byte from accepted read", 32'(rd), 32'(hb_of(rom_fn({4'h5, 8'h33}))));

        // R11: index write in start cycle
        @(negedge clk);
        sfr_addr = 8'h07; sfr_wr = 1'b1; sfr_wdata = 8'hC4;
        start = 1'b1; start_last = 1'b0; pc_page = 4'h9; dst_addr = 7'h01;
        #1;
        chk("R11 address uses old index", 32'(rom_addr), 32'({4'h9, 8'h33}));
        @(negedge clk);
        start = 1'b0; sfr_wr = 1'b0;
        sfr_read(8'h07, rd);
        chk("R11 new index stored", 32'(rd), 32'hC4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [7:0] SFR_IDX();
        return 8'h07;
    endfunction

    localparam logic [7:0] SFR_HB_ADDR = 8'h08;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule